// File: doc/BRIEF.md
# USB Line State and Speed Monitor

This block watches the two data lines of a low-/full-speed USB port, oversampled on a fast local clock. Both lines pass through a synchronizer. The block then turns each sample pair into a line symbol (J, K, SE0 or SE1). The J/K meaning depends on the speed mode that is active at that moment. The block also measures every stretch of SE0, and when the line leaves SE0 it judges how long the stretch lasted. A long stretch is a bus reset, and a medium one on a low-speed link is a keep-alive. The block also tracks which speed the attached device signals with.

The speed mode is a three-state machine: `MD_FS` (full speed), `MD_LS` (low speed) and `MD_LSRP` (low bit rate with full-speed polarity, used after a preamble). It has these transitions:
- Synchronous reset loads the configured speed.
- A preamble pulse from the framer moves it to `MD_LSRP`.
- In automatic configuration, the idle level seen after any SE0 of two or more samples selects `MD_FS` or `MD_LS`.
- A bus reset restores the configured speed.

The SE0 timer is a second machine with three states:
- `T_LINE`: the line is not in SE0.
- `T_SE0`: counting SE0 samples, with the count saturating.
- `T_END`: a single cycle after SE0 ends. The count is held and judged here, and the level the line returned to is kept.

From `T_END` the timer goes back to `T_LINE`, or straight to `T_SE0` if SE0 has already returned. Bit recovery, NRZI decoding and packet framing belong to later stages.

Top module: `usb_line_monitor`

## Requirements
- R1: Each data line passes through SYNC_STAGES flops (default two). A change on `dp_i`/`dm_i` driven between edges shows on `sym_o` after the second following rising edge, not before. The synchronizer flops reset to D+ high, D- low.
- R2: Both synchronized lines low gives `sym_o` = 2'b00 (SE0), and both high gives 2'b11 (SE1), in every speed mode.
- R3: In `MD_FS` (`mode_o` = 2'b00) and in `MD_LSRP` (`mode_o` = 2'b10), D+ high with D- low gives J (2'b01) and D+ low with D- high gives K (2'b10). In `MD_LS` (`mode_o` = 2'b01) the two are swapped.
- R4: While `rst_n` is low at a clock edge, the mode loads `MD_LS` if `cfg_i` = 2'b10 and `MD_FS` otherwise. Both strobes are low.
- R5: An SE0 run longer than RST_CYC = floor(SAMPLE_HZ*25/10^7) samples (more than 2.5 us) raises `bus_rst_o` for exactly one cycle, in the cycle after the synchronized line leaves SE0.
- R6: An SE0 run longer than KA_CYC = floor(SAMPLE_HZ*12/10^7) samples (more than 1.2 us) and at most RST_CYC samples raises `keep_alive_o` for one cycle, only if the mode is `MD_LS` at that moment. In `MD_FS` and `MD_LSRP` it stays low.
- R7: With `cfg_i` = 2'b00 (automatic; 2'b11 acts the same), after an SE0 run of at least 2 samples the returning level sets the mode. D+ high with D- low gives `MD_FS`, D- high with D+ low gives `MD_LS`, and SE1 leaves the mode as it was.
- R8: A bus reset restores the configured mode: `MD_FS` for `cfg_i` = 2'b01, `MD_LS` for 2'b10. In automatic configuration the returning idle level decides, and an SE1 return gives `MD_FS`. A preamble-selected mode is dropped.
- R9: A one-cycle `pre_i` pulse switches the mode to `MD_LSRP` at the next edge. The mode stays there until a bus reset, or until an automatic idle detection.
- R10: A single-sample SE0 changes neither the mode nor either strobe.
- R11: Changing `cfg_i` alone does not alter the mode. In forced configuration, an SE0 that is not a bus reset leaves the mode as it is.
- R12: `bus_rst_o` and `keep_alive_o` are never high together, and neither stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, SAMPLE_HZ |
| rst_n | input | 1 | Synchronous active-low reset |
| dp_i | input | 1 | Raw D+ line sample |
| dm_i | input | 1 | Raw D- line sample |
| cfg_i | input | 2 | Speed configuration: 00 automatic, 01 forced full, 10 forced low, 11 automatic |
| pre_i | input | 1 | Preamble seen by the framer (one-cycle pulse) |
| sym_o | output | 2 | Line symbol: 00 SE0, 01 J, 10 K, 11 SE1 |
| mode_o | output | 2 | Active speed: 00 full, 01 low, 10 low with full-speed polarity |
| bus_rst_o | output | 1 | One-cycle bus reset strobe |
| keep_alive_o | output | 1 | One-cycle low-speed keep-alive strobe |

## Verification
The bench builds the monitor with SAMPLE_HZ = 4 MHz and the default two synchronizer stages. This puts the bus reset limit at 10 samples and the keep-alive limit at 4 samples. Every threshold boundary (1, 4, 5, 10 and 11 samples of SE0) can then be reached in a few cycles. Random SE0 lengths from 1 to 14 land on both sides of each limit, mixed with preamble pulses, configuration changes and J/K/SE1 traffic.

// File: rtl/ulm_pkg.sv
package ulm_pkg;

    typedef enum logic [1:0] {
        SYM_SE0 = 2'b00,
        SYM_J   = 2'b01,
        SYM_K   = 2'b10,
        SYM_SE1 = 2'b11
    } line_sym_e;

    typedef enum logic [1:0] {
        MD_FS   = 2'b00,
        MD_LS   = 2'b01,
        MD_LSRP = 2'b10
    } speed_e;

    typedef enum logic [1:0] {
        T_LINE,
        T_SE0,
        T_END
    } tmr_e;

endpackage

// File: rtl/ulm_sync.sv
module ulm_sync #(
    parameter int unsigned    W       = 2,
    parameter int unsigned    STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] stg_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_q <= {STAGES{RST_VAL}};
        end else begin
            stg_q[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                stg_q[s] <= stg_q[s-1];
            end
        end
    end

    assign q = stg_q[STAGES-1];

endmodule

// File: rtl/ulm_classify.sv
module ulm_classify
    import ulm_pkg::*;
(
    input  logic      dp,
    input  logic      dm,
    input  speed_e    mode,
    output line_sym_e sym
);

    // Low-speed signalling swaps the meaning of the two differential states.
    always_comb begin
        unique case ({dp, dm})
            2'b00:   sym = SYM_SE0;
            2'b11:   sym = SYM_SE1;
            2'b10:   sym = (mode == MD_LS) ? SYM_K : SYM_J;
            default: sym = (mode == MD_LS) ? SYM_J : SYM_K;
        endcase
    end

endmodule

// File: rtl/ulm_se0_timer.sv
module ulm_se0_timer
    import ulm_pkg::*;
#(
    parameter int unsigned RST_CYC = 120,
    parameter int unsigned KA_CYC  = 57
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dp,
    input  logic       dm,
    output logic       end_evt,
    output logic       len_rst,
    output logic       len_ka,
    output logic       len_min,
    output logic [1:0] end_lvl
);

    localparam int unsigned    CNT_MAX = RST_CYC + 1;
    localparam int unsigned    CW      = $clog2(CNT_MAX + 1);
    localparam logic [CW-1:0]  SAT     = CW'(CNT_MAX);
    localparam logic [CW-1:0]  RST_LIM = CW'(RST_CYC);
    localparam logic [CW-1:0]  KA_LIM  = CW'(KA_CYC);
    localparam logic [CW-1:0]  MIN_LEN = CW'(2);

    tmr_e          st_q, st_d;
    logic [CW-1:0] cnt_q;
    logic [1:0]    lvl_q;
    logic          se0;

    assign se0 = !dp && !dm;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            T_LINE:  if (se0) st_d = T_SE0;
            T_SE0:   if (!se0) st_d = T_END;
            T_END:   st_d = se0 ? T_SE0 : T_LINE;
            default: st_d = T_LINE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= T_LINE;
            cnt_q <= '0;
            lvl_q <= 2'b10;
        end else begin
            st_q <= st_d;
            if (st_q != T_SE0 && se0) begin
                cnt_q <= CW'(1);
            end else if (st_q == T_SE0 && se0 && cnt_q != SAT) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (st_q == T_SE0 && !se0) begin
                lvl_q <= {dp, dm};
            end
        end
    end

    always_comb begin
        end_evt = (st_q == T_END);
        len_rst = (cnt_q > RST_LIM);
        len_ka  = (cnt_q > KA_LIM);
        len_min = (cnt_q >= MIN_LEN);
        end_lvl = lvl_q;
    end

    p_cnt_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= SAT);

    p_end_once_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == T_END) |=> (st_q != T_END));

endmodule

// File: rtl/usb_line_monitor.sv
module usb_line_monitor
    import ulm_pkg::*;
#(
    parameter int unsigned SAMPLE_HZ   = 48_000_000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dp_i,
    input  logic       dm_i,
    input  logic [1:0] cfg_i,
    input  logic       pre_i,
    output logic [1:0] sym_o,
    output logic [1:0] mode_o,
    output logic       bus_rst_o,
    output logic       keep_alive_o
);

    localparam longint unsigned HZ64    = 64'(SAMPLE_HZ);
    localparam int unsigned     RST_CYC = int'((HZ64 * 64'd25) / 64'd10_000_000);
    localparam int unsigned     KA_CYC  = int'((HZ64 * 64'd12) / 64'd10_000_000);

    logic [1:0] line_s;
    line_sym_e  sym;
    speed_e     mode_q, mode_d;
    logic       end_evt, len_rst, len_ka, len_min;
    logic [1:0] end_lvl;
    logic       cfg_auto, cfg_ls;

    ulm_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b10)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({dp_i, dm_i}),
        .q     (line_s)
    );

    ulm_classify u_cls (
        .dp   (line_s[1]),
        .dm   (line_s[0]),
        .mode (mode_q),
        .sym  (sym)
    );

    ulm_se0_timer #(.RST_CYC(RST_CYC), .KA_CYC(KA_CYC)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .dp      (line_s[1]),
        .dm      (line_s[0]),
        .end_evt (end_evt),
        .len_rst (len_rst),
        .len_ka  (len_ka),
        .len_min (len_min),
        .end_lvl (end_lvl)
    );

    always_comb begin
        unique case (cfg_i)
            2'b01:   begin cfg_auto = 1'b0; cfg_ls = 1'b0; end
            2'b10:   begin cfg_auto = 1'b0; cfg_ls = 1'b1; end
            default: begin cfg_auto = 1'b1; cfg_ls = 1'b0; end
        endcase
    end

    // Speed-mode machine: the end of an SE0 run outranks a preamble.
    always_comb begin
        mode_d = mode_q;
        if (end_evt && len_min) begin
            if (len_rst) begin
                mode_d = cfg_ls ? MD_LS : MD_FS;
            end
            if (cfg_auto) begin
                unique case (end_lvl)
                    2'b10:   mode_d = MD_FS;
                    2'b01:   mode_d = MD_LS;
                    default: ;
                endcase
            end
        end else if (pre_i) begin
            mode_d = MD_LSRP;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= cfg_ls ? MD_LS : MD_FS;
        end else begin
            mode_q <= mode_d;
        end
    end

    always_comb begin
        sym_o        = sym;
        mode_o       = mode_q;
        bus_rst_o    = end_evt && len_rst;
        keep_alive_o = end_evt && !len_rst && len_ka && (mode_q == MD_LS);
    end

    p_se0_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (line_s == 2'b00) |-> (sym_o == 2'b00));

    p_se1_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (line_s == 2'b11) |-> (sym_o == 2'b11));

    p_ls_swap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b01 && line_s == 2'b10) |-> (sym_o == 2'b10));

    p_ka_only_ls_r6: assert property (@(posedge clk) disable iff (!rst_n)
        keep_alive_o |-> (mode_o == 2'b01));

    p_forced_restore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rst_o && cfg_i == 2'b01) |=> (mode_o == 2'b00));

    p_preamble_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_i && !end_evt) |=> (mode_o == 2'b10));

    p_short_se0_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (end_evt && !len_min && !pre_i) |=> $stable(mode_o));

    p_strobe_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rst_o && keep_alive_o));

    p_rst_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst_o |=> !bus_rst_o);

    p_ka_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        keep_alive_o |=> !keep_alive_o);

endmodule

// File: tb/sim_usb_line_monitor.sv
module sim_usb_line_monitor;

    localparam int CLK_PERIOD = 10;
    localparam int SAMPLE_HZ  = 4_000_000;
    localparam int RST_LIM    = SAMPLE_HZ / 10_000_000.0 * 25 > 0 ? (SAMPLE_HZ / 400_000) : 0; // 2.5 us -> 10
    localparam int KA_LIM     = (SAMPLE_HZ * 12) / 10_000_000;                                   // 1.2 us -> 4

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dp = 1'b1, dm = 1'b0;
    logic [1:0] cfg = 2'b10;
    logic       pre = 1'b0;
    logic [1:0] sym, mode;
    logic       bus_rst, keep_alive;

    int  n_chk = 0, n_fail = 0;
    int  rst_seen = 0, ka_seen = 0;
    bit  done = 1'b0;
    logic [1:0] m_mode;

    always #(CLK_PERIOD/2) clk = ~clk;

    usb_line_monitor #(.SAMPLE_HZ(SAMPLE_HZ), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .dp_i(dp), .dm_i(dm), .cfg_i(cfg), .pre_i(pre),
        .sym_o(sym), .mode_o(mode), .bus_rst_o(bus_rst), .keep_alive_o(keep_alive)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_rst) rst_seen++;
            if (keep_alive) ka_seen++;
        end
    end

    function automatic logic [1:0] exp_sym(logic [1:0] lvl, logic [1:0] md);
        if (lvl == 2'b00) return 2'b00;
        if (lvl == 2'b11) return 2'b11;
        if (md == 2'b01) return (lvl == 2'b10) ? 2'b10 : 2'b01;
        return (lvl == 2'b10) ? 2'b01 : 2'b10;
    endfunction

    function automatic logic [1:0] next_mode(logic [1:0] cur, logic [1:0] c, int len, logic [1:0] lvl);
        logic [1:0] m;
        logic       auto_c;
        auto_c = (c == 2'b00) || (c == 2'b11);
        m = cur;
        if (len < 2) return cur;
        if (len > RST_LIM) m = (c == 2'b10) ? 2'b01 : 2'b00;
        if (auto_c) begin
            if (lvl == 2'b10) m = 2'b00;
            else if (lvl == 2'b01) m = 2'b01;
        end
        return m;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic drive(logic [1:0] lvl, int n);
        {dp, dm} = lvl;
        repeat (n) @(negedge clk);
    endtask

    // SE0 for len samples, then return to lvl and hold.
    task automatic burst(string req, int len, logic [1:0] lvl);
        int exp_r, exp_k;
        rst_seen = 0;
        ka_seen  = 0;
        exp_r = (len > RST_LIM) ? 1 : 0;
        exp_k = (len > KA_LIM && len <= RST_LIM && m_mode == 2'b01) ? 1 : 0;
        m_mode = next_mode(m_mode, cfg, len, lvl);
        drive(2'b00, len);
        drive(lvl, 6);
        chk({req, " mode"}, mode, m_mode);
        chk({req, " sym"}, sym, exp_sym(lvl, m_mode));
        chk({req, " bus reset strobes"}, rst_seen, exp_r);
        chk({req, " keep-alive strobes"}, ka_seen, exp_k);
    endtask

    task automatic preamble(string req);
        pre = 1'b1;
        @(negedge clk);
        pre = 1'b0;
        m_mode = 2'b10;
        chk(req, mode, 2'b10);
        @(negedge clk);
    endtask

    task automatic traffic(int n);
        logic [1:0] lvl;
        rst_seen = 0;
        ka_seen  = 0;
        lvl = 2'b10;
        for (int i = 0; i < n; i++) begin
            case ($urandom % 3)
                0: lvl = 2'b10;
                1: lvl = 2'b01;
                default: lvl = 2'b11;
            endcase
            drive(lvl, 1);
        end
        drive(lvl, 4);
        chk("R3 traffic sym", sym, exp_sym(lvl, m_mode));
        chk("R11 traffic mode", mode, m_mode);
        chk("R12 traffic strobes", rst_seen + ka_seen, 0);
    endtask

    task automatic report();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        void'($urandom(32'd2024));
        // R4: reset state with forced low speed
        repeat (3) @(negedge clk);
        chk("R4 reset mode", mode, 2'b01);
        chk("R4 reset sym", sym, 2'b10);
        chk("R4 reset strobes", bus_rst + keep_alive, 0);
        rst_n = 1'b1;
        m_mode = 2'b01;
        drive(2'b10, 3);

        // R1: two-edge synchronizer latency
        {dp, dm} = 2'b01;
        @(negedge clk);
        chk("R1 after one edge", sym, 2'b10);
        @(negedge clk);
        chk("R1 after two edges", sym, 2'b01);
        drive(2'b10, 3);

        // R7 / R6 / R5 / R8 / R10 directed, automatic configuration
        cfg = 2'b00;
        drive(2'b10, 1);
        chk("R11 cfg change alone", mode, 2'b01);
        burst("R7 detect full", 3, 2'b10);
        burst("R10 single sample", 1, 2'b01);
        burst("R7 detect low", 3, 2'b01);
        burst("R6 keep-alive at reset limit", RST_LIM, 2'b01);
        burst("R6 keep-alive just above limit", KA_LIM + 1, 2'b01);
        burst("R6 at keep-alive limit", KA_LIM, 2'b01);
        burst("R5 reset auto low", RST_LIM + 1, 2'b01);
        burst("R8 reset auto SE1", RST_LIM + 1, 2'b11);
        burst("R6 no keep-alive full", 7, 2'b10);
        preamble("R9 preamble");
        burst("R9 repeater kept on SE1", 7, 2'b11);
        burst("R2 SE1 level", 2, 2'b11);
        // forced configurations
        cfg = 2'b10;
        burst("R8 forced low", RST_LIM + 3, 2'b10);
        cfg = 2'b01;
        drive(2'b10, 2);
        chk("R11 forced change alone", mode, 2'b01);
        burst("R11 short SE0 forced", 3, 2'b01);
        preamble("R9 preamble forced");
        burst("R8 forced full drops repeater", RST_LIM + 2, 2'b01);
        burst("R3 full mapping K", 2, 2'b01);

        // random phase
        for (int it = 0; it < 300; it++) begin
            int r;
            r = $urandom % 10;
            if (r == 0) begin
                cfg = 2'($urandom % 3);
                drive({dp, dm}, 1);
            end else if (r == 1) begin
                preamble("R9 random preamble");
            end else if (r < 4) begin
                traffic(2 + $urandom % 7);
            end else begin
                int len;
                logic [1:0] lvl;
                len = 1 + $urandom % 14;
                case ($urandom % 5)
                    0, 1: lvl = 2'b10;
                    2, 3: lvl = 2'b01;
                    default: lvl = 2'b11;
                endcase
                burst("R5/R6/R7 random SE0", len, lvl);
            end
        end
        done = 1'b1;
        report();
    end

endmodule